// File: doc/BRIEF.md
# Multi-Width Countdown Timer Bank

This block groups four hardware timers behind one small register bus. Three of them are reloadable down-counters: two are 16 bits wide and one is 32 bits wide. Each of the three decrements on an external tick strobe, raises a level interrupt when its count underflows, and then reloads itself. The fourth timer is a 40-bit up-counter that runs freely on a faster tick and never interrupts. Software reads it to measure elapsed time between interrupts.

Tick strobes arrive from prescalers outside the block as single-cycle pulses. Three strobes are used: a mid-rate tick for the down-counters (about 508 kHz), a slow tick as their alternative source, and a fast tick (983.04 kHz) for the free-running counter. Writes take one cycle. Reads are combinational from the addressed register.

Top module: `timer_bank`

## Requirements
- R1: After reset every counter, load register and control register reads zero, and all three interrupt outputs are low.
- R2: Word address map (4-bit address). Down-timer k (k = 0, 1, 2) occupies addresses 4k+0 (load, read/write), 4k+1 (current count, read only), 4k+2 (control) and 4k+3 (interrupt clear, write only). Timers 0 and 1 keep the low 16 bits of a written load value and timer 2 keeps all 32 bits. Address 12 reads the free-running count bits 31:0. Address 13 holds the free-running enable in bit 8 and reads count bits 39:32 in bits 7:0.
- R3: Control bits are: bit 7 enable, bit 6 periodic reload, bit 3 tick select. Tick select 1 picks the mid-rate strobe and 0 picks the slow strobe. Control reads back only these three bits; all other bits read zero.
- R4: An enabled down-timer decrements by one on each strobe of its selected tick. Strobes of the unselected tick have no effect.
- R5: With periodic reload set, a load value N gives an underflow on the (N+1)-th selected tick after loading, and the count then returns to N.
- R6: With periodic reload clear, an underflow sets the count to the all-ones value of the timer's width.
- R7: On every underflow the timer's interrupt output rises on the following cycle.
- R8: A write to the load address sets the count to the written value on the next clock, whether or not the timer is enabled.
- R9: While disabled, a down-timer holds its count and raises no interrupt.
- R10: An interrupt output stays high until its clear address is written. When a clear write and an underflow fall on the same cycle, the interrupt remains high.
- R11: When enabled, the free-running counter increments by one on each fast strobe. When disabled, it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_mid | input | 1 | Mid-rate tick strobe for the down-timers |
| tick_slow | input | 1 | Slow tick strobe, alternative source for the down-timers |
| tick_fast | input | 1 | Fast tick strobe for the free-running counter |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 3 | Level interrupts of down-timers 0 to 2 |

## Verification
The assertions check on every cycle that a pending interrupt persists until a clear, that an underflow raises the interrupt, and that a clear without a coincident underflow drops it. They also check that a periodic reload restores the load value, that a disabled timer keeps its count, and that the free-running counter advances by exactly one per enabled fast tick. The bench scenarios are needed for the rest: the address map, the truncation to each timer's width, the N+1 tick period, the all-ones reload, the choice between the two tick sources, and control readback.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NUM_DN  = 3;

  // control field positions
  localparam int unsigned CTL_EN  = 7;
  localparam int unsigned CTL_PER = 6;
  localparam int unsigned CTL_SEL = 3;

  // register slot inside one down-timer window
  typedef enum logic [1:0] {
    SLOT_LOAD  = 2'd0,
    SLOT_COUNT = 2'd1,
    SLOT_CTRL  = 2'd2,
    SLOT_CLR   = 2'd3
  } dn_slot_e;

  localparam logic [1:0] FREE_WIN  = 2'd3;
  localparam logic [1:0] FREE_LOW  = 2'd0;
  localparam logic [1:0] FREE_HIGH = 2'd1;
  localparam int unsigned FREE_EN_BIT = 8;
endpackage

// File: rtl/tb_rst_sync.sv
module tb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/dn_timer.sv
module dn_timer
  import timer_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_mid,
  input  logic             tick_slow,
  input  logic             wr_load,
  input  logic             wr_ctrl,
  input  logic             wr_clr,
  input  logic [BUS_W-1:0] wdata,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] load_o,
  output logic [7:0]       ctrl_o,
  output logic             irq_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] ld_q, ld_d;
  logic             en_q, en_d;
  logic             per_q, per_d;
  logic             sel_q, sel_d;
  logic             irq_q, irq_d;
  logic             tick_pick, step, uflow;

  always_comb begin
    tick_pick = sel_q ? tick_mid : tick_slow;
    step      = en_q && tick_pick;
    uflow     = step && (cnt_q == '0) && !wr_load;

    cnt_d = cnt_q;
    ld_d  = ld_q;
    en_d  = en_q;
    per_d = per_q;
    sel_d = sel_q;
    irq_d = irq_q;

    if (wr_ctrl) begin
      en_d  = wdata[CTL_EN];
      per_d = wdata[CTL_PER];
      sel_d = wdata[CTL_SEL];
    end

    if (wr_load) begin
      ld_d  = wdata[WIDTH-1:0];
      cnt_d = wdata[WIDTH-1:0];
    end else if (step) begin
      if (cnt_q == '0) cnt_d = per_q ? ld_q : ALL_ONES;
      else             cnt_d = cnt_q - 1'b1;
    end

    if (wr_clr) irq_d = 1'b0;
    if (uflow)  irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ld_q  <= '0;
      en_q  <= 1'b0;
      per_q <= 1'b0;
      sel_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ld_q  <= ld_d;
      en_q  <= en_d;
      per_q <= per_d;
      sel_q <= sel_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    ctrl_o          = '0;
    ctrl_o[CTL_EN]  = en_q;
    ctrl_o[CTL_PER] = per_q;
    ctrl_o[CTL_SEL] = sel_q;
  end

  assign count_o = cnt_q;
  assign load_o  = ld_q;
  assign irq_o   = irq_q;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_clr) |=> irq_o); // R10
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !(en_q && tick_pick && count_o == '0 && !wr_load)) |=> !irq_o); // R10
  AST_UFLOW_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[CTL_EN] && tick_pick && count_o == '0 && !wr_load) |=> irq_o); // R7
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[CTL_EN] && ctrl_o[CTL_PER] && tick_pick && count_o == '0 && !wr_load)
      |=> count_o == $past(load_o)); // R5
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_o[CTL_EN] && !wr_load) |=> $stable(count_o)); // R9
endmodule

// File: rtl/free_counter.sv
module free_counter #(
  parameter int unsigned WIDTH = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic             en_val,
  output logic [WIDTH-1:0] count_o,
  output logic             en_o
);
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;

  always_comb begin
    en_d  = wr_en ? en_val : en_q;
    cnt_d = (en_q && tick) ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign count_o = cnt_q;
  assign en_o    = en_q;

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && tick) |=> count_o == $past(count_o) + 1'b1); // R11
  AST_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o || !tick) |=> $stable(count_o)); // R11
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned WIDE_W   = 32,
  parameter int unsigned FREE_W   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_mid,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_DN-1:0] irq
);
  localparam int unsigned FREE_HI_W = FREE_W - BUS_W;

  logic              rst_ni;
  logic [1:0]        win;
  logic [1:0]        slot;
  logic [BUS_W-1:0]  dn_load  [NUM_DN];
  logic [BUS_W-1:0]  dn_count [NUM_DN];
  logic [7:0]        dn_ctrl  [NUM_DN];
  logic [FREE_W-1:0] free_cnt;
  logic              free_en;
  logic              free_wr;

  tb_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_ni)
  );

  assign win  = bus_addr[3:2];
  assign slot = bus_addr[1:0];

  for (genvar k = 0; k < NUM_DN; k++) begin : g_dn
    localparam int unsigned W = (k == NUM_DN - 1) ? WIDE_W : NARROW_W;
    logic [W-1:0] cnt_w, ld_w;
    logic         sel_me;

    assign sel_me = bus_wr && (win == 2'(k));

    dn_timer #(.WIDTH(W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_ni),
      .tick_mid (tick_mid),
      .tick_slow(tick_slow),
      .wr_load  (sel_me && slot == SLOT_LOAD),
      .wr_ctrl  (sel_me && slot == SLOT_CTRL),
      .wr_clr   (sel_me && slot == SLOT_CLR),
      .wdata    (bus_wdata),
      .count_o  (cnt_w),
      .load_o   (ld_w),
      .ctrl_o   (dn_ctrl[k]),
      .irq_o    (irq[k])
    );

    assign dn_count[k] = BUS_W'(cnt_w);
    assign dn_load[k]  = BUS_W'(ld_w);
  end

  assign free_wr = bus_wr && win == FREE_WIN && slot == FREE_HIGH;

  free_counter #(.WIDTH(FREE_W)) u_free (
    .clk    (clk),
    .rst_n  (rst_ni),
    .tick   (tick_fast),
    .wr_en  (free_wr),
    .en_val (bus_wdata[FREE_EN_BIT]),
    .count_o(free_cnt),
    .en_o   (free_en)
  );

  always_comb begin
    bus_rdata = '0;
    if (win == FREE_WIN) begin
      if (slot == FREE_LOW) begin
        bus_rdata = free_cnt[BUS_W-1:0];
      end else if (slot == FREE_HIGH) begin
        bus_rdata[FREE_HI_W-1:0] = free_cnt[FREE_W-1:BUS_W];
        bus_rdata[FREE_EN_BIT]   = free_en;
      end
    end else begin
      case (slot)
        SLOT_LOAD:  bus_rdata = dn_load[win];
        SLOT_COUNT: bus_rdata = dn_count[win];
        SLOT_CTRL:  bus_rdata = BUS_W'(dn_ctrl[win]);
        default:    bus_rdata = '0;
      endcase
    end
  end

  AST_IRQ_IDLE_RESET: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> irq == '0); // R1
endmodule

// File: tb/timer_bank_tb.sv
module timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_mid, tick_slow, tick_fast;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .tick_mid(tick_mid), .tick_slow(tick_slow),
    .tick_fast(tick_fast), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  tmr;
    logic [31:0] load;
    logic [7:0]  ctrl;
    logic [7:0]  nticks;
    logic [31:0] exp_val;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'd5,        8'hC8, 8'd3, 32'd2,         1'b0}, // R4
    '{2'd0, 32'd5,        8'hC8, 8'd6, 32'd5,         1'b1}, // R5
    '{2'd1, 32'h0001_2345, 8'hC8, 8'd1, 32'h2344,     1'b0}, // R2
    '{2'd2, 32'h0001_2345, 8'hC8, 8'd2, 32'h0001_2343, 1'b0}, // R2
    '{2'd2, 32'd0,        8'hC8, 8'd1, 32'd0,         1'b1}, // R5
    '{2'd1, 32'd2,        8'h88, 8'd3, 32'h0000_FFFF, 1'b1}, // R6
    '{2'd2, 32'd1,        8'h88, 8'd2, 32'hFFFF_FFFF, 1'b1}, // R6
    '{2'd0, 32'd7,        8'h48, 8'd4, 32'd7,         1'b0}, // R9
    '{2'd0, 32'd7,        8'hC0, 8'd4, 32'd7,         1'b0}  // R4 unselected tick
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_mid(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_mid = 1'b1;
      @(posedge clk); #1 tick_mid = 1'b0;
    end
  endtask

  task automatic pulse_slow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_slow = 1'b1;
      @(posedge clk); #1 tick_slow = 1'b0;
    end
  endtask

  task automatic pulse_fast(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_fast = 1'b1;
      @(posedge clk); #1 tick_fast = 1'b0;
    end
  endtask

  function automatic logic [3:0] adr(input int t, input int slot);
    return 4'(t * 4 + slot);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    rst_n = 1'b0; tick_mid = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int t = 0; t < 3; t++) begin
      rd(adr(t, 0), d); chk("R1 load", d, 32'd0);
      rd(adr(t, 1), d); chk("R1 count", d, 32'd0);
      rd(adr(t, 2), d); chk("R1 ctrl", d, 32'd0);
    end
    rd(4'd12, d); chk("R1 free low", d, 32'd0);
    chk("R1 irq", {29'd0, irq}, 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      int t;
      t = int'(VECS[v].tmr);
      wr(adr(t, 2), 32'h48);
      wr(adr(t, 3), 32'd0);
      wr(adr(t, 0), VECS[v].load);
      wr(adr(t, 2), 32'(VECS[v].ctrl));
      pulse_mid(int'(VECS[v].nticks));
      rd(adr(t, 1), d);
      chk($sformatf("R5 vector %0d count", v), d, VECS[v].exp_val);
      chk($sformatf("R7 vector %0d irq", v), 32'(irq[t]), 32'(VECS[v].exp_irq));
      wr(adr(t, 2), 32'h48);
      wr(adr(t, 3), 32'd0);
    end

    // R3 control readback masks unused bits
    wr(adr(0, 2), 32'hFF);
    rd(adr(0, 2), d); chk("R3 ctrl readback", d, 32'hC8);
    wr(adr(0, 2), 32'h48);

    // R3 slow tick source
    wr(adr(0, 0), 32'd3);
    wr(adr(0, 2), 32'hC0);
    pulse_slow(2);
    rd(adr(0, 1), d); chk("R3 slow tick count", d, 32'd1);
    wr(adr(0, 2), 32'h48);

    // R8 load while running
    wr(adr(1, 0), 32'd10);
    wr(adr(1, 2), 32'hC8);
    pulse_mid(2);
    rd(adr(1, 1), d); chk("R8 before reload", d, 32'd8);
    wr(adr(1, 0), 32'd20);
    rd(adr(1, 1), d); chk("R8 after load write", d, 32'd20);
    wr(adr(1, 2), 32'h48);

    // R10 level until clear, and clear racing underflow
    wr(adr(0, 3), 32'd0);
    wr(adr(0, 0), 32'd0);
    wr(adr(0, 2), 32'hC8);
    pulse_mid(1);
    repeat (3) @(posedge clk);
    #1 chk("R10 irq held", 32'(irq[0]), 32'd1);
    wr(adr(0, 3), 32'd0);
    #1 chk("R10 irq cleared", 32'(irq[0]), 32'd0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = adr(0, 3); bus_wdata = '0; tick_mid = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; tick_mid = 1'b0;
    chk("R10 clear with underflow", 32'(irq[0]), 32'd1);
    wr(adr(0, 2), 32'h48);
    wr(adr(0, 3), 32'd0);

    // R11 free-running counter
    pulse_fast(2);
    rd(4'd12, d); chk("R11 idle when disabled", d, 32'd0);
    wr(4'd13, 32'h100);
    pulse_fast(5);
    rd(4'd12, d); chk("R11 counts fast ticks", d, 32'd5);
    rd(4'd13, d); chk("R2 free high word", d, 32'h100);
    pulse_mid(3);
    rd(4'd12, d); chk("R11 ignores mid tick", d, 32'd5);
    wr(4'd13, 32'h0);
    pulse_fast(4);
    rd(4'd12, d); chk("R11 hold when disabled", d, 32'd5);
    chk("R9 no stray irq", {29'd0, irq}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule